// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Distributed Refresh

This block is a synchronous controller that connects a simple single-beat request port to a DRAM device with asynchronous-style strobes. Each request carries a full word address. The controller splits that address into a row part (upper bits) and a column part (lower bits) and places them one after the other on a single shared address bus. It then drives the active-low row strobe, column strobe, write-enable and output-enable lines in the order the device needs, and returns read data together with a one-cycle valid pulse.

The controller also refreshes the device itself. A free-running interval timer divides the full-array refresh period by the row count. On each tick it raises a pending refresh. A row counter supplies the next row to refresh. A refresh that becomes due during an access waits until that access is finished. It is then served before any new request. Each refresh is a row-strobe-only cycle: the column strobe stays high throughout.

Minimum strobe-low time, precharge time, row-to-column delay and column-strobe-low time are parameters counted in clock cycles.

Top module: `mux_dram_ctrl`

## Requirements
- R1: The row is bits [ROW_W+COL_W-1:COL_W] of the request address, and the column is bits [COL_W-1:0]. The row value is on the address bus at least one cycle before the row strobe falls, and it does not change across that falling edge.
- R2: The column address and write-enable do not change across the falling edge of the column strobe. Write-enable is low for a write and high for a read. For a write, the write data is driven, with the data drive enable high, and stable across that falling edge.
- R3: The column strobe is low only while the row strobe is low. The row strobe stays low until the column strobe has returned high.
- R4: Read data is captured while the row and column strobes are low, write-enable is high and output-enable is low. It is presented on rd_data with rd_valid high for exactly one cycle, in the same cycle that the column strobe returns high. A write produces no rd_valid.
- R5: Every row-strobe low period lasts at least T_RAS cycles. Every row-strobe high period between two low periods lasts at least T_RP cycles. The column strobe falls at least T_RCD cycles after the row strobe falls.
- R6: A refresh is a row-strobe pulse with the column strobe held high. The refresh row starts at 0 after reset, increases by one with each refresh and wraps from 2**ROW_W-1 back to 0.
- R7: A refresh becomes due every REF_PERIOD_CYC / 2**ROW_W cycles. A due refresh waits only for the access in progress, and it is started before any pending request. req_ready is low while any refresh or access is in progress. The gap between consecutive refreshes never exceeds the interval plus one access, one precharge and one refresh.
- R8: While reset is high and right after it, all four strobes are high, the data drive enable is low, rd_valid is low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Full word address (row above column) |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted on a cycle where valid and ready are both high |
| rd_data | output | DATA_W | Read data |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write-enable, active low |
| dram_oe_n | output | 1 | Output-enable, active low |
| dram_dq_out | output | DATA_W | Data driven toward the device |
| dram_dq_oe | output | 1 | High while dram_dq_out is driven |
| dram_dq_in | input | DATA_W | Data returned by the device |

## Verification
A behavioural device model latches the row and the column on the strobe edges and checks that each latched pair equals the requested address. Every location is written and read back in two passes. The first pass uses ascending addresses and one data pattern. The second pass writes in descending order with a second pattern and reads in a strided order. Together the passes separate a row/column swap or a shifted split from a correct split, and they expose stale data left from the first pass. Refresh ticks fall at different points of the busy sweeps and during a long idle stretch. This shows both the case where a refresh must wait for an access and the case where it starts at once. The row counter wraps more than once during the run.

// File: rtl/mdc_pkg.sv
`timescale 1ns/1ps
package mdc_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ROWSET,
    S_RCD,
    S_COLSET,
    S_CAS,
    S_REFSET,
    S_REFLOW,
    S_PRE
  } seq_state_t;
endpackage

// File: rtl/mdc_refresh.sv
`timescale 1ns/1ps
module mdc_refresh #(
  parameter int ROW_W    = 12,
  parameter int INTERVAL = 3125
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_done,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TW = $clog2(INTERVAL + 1);

  logic [TW-1:0] tmr;
  logic          tick;

  assign tick = (tmr == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr      <= '0;
      ref_pend <= 1'b0;
      ref_row  <= '0;
    end else begin
      tmr      <= tick ? '0 : tmr + 1'b1;
      ref_pend <= tick | (ref_pend & ~ref_done);
      if (ref_done) ref_row <= ref_row + 1'b1;
    end
  end
endmodule

// File: rtl/mdc_seq.sv
`timescale 1ns/1ps
module mdc_seq
  import mdc_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 12,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RAS  = 8,
  parameter int T_RP   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_go,
  input  logic              acc_wr,
  input  logic [ROW_W-1:0]  acc_row,
  input  logic [COL_W-1:0]  acc_col,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic              ref_pend,
  input  logic [ROW_W-1:0]  ref_row,
  output logic              idle,
  output logic              ref_done,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [BUS_W-1:0]  addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int M1   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
  localparam int M2   = (T_RAS > T_RP) ? T_RAS : T_RP;
  localparam int TMAX = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(TMAX + 1);

  seq_state_t       state;
  logic [CW-1:0]    cnt;
  logic [CW-1:0]    age;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  logic             ras_met;

  assign idle    = (state == S_IDLE);
  // after the coming edge, the row strobe will have been low age+1 cycles
  assign ras_met = ({1'b0, age} + 1'b1) >= (CW+1)'(T_RAS);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      cnt      <= '0;
      age      <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      ras_n    <= 1'b1;
      cas_n    <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      addr     <= '0;
      dq_out   <= '0;
      dq_oe    <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      ref_done <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      ref_done <= 1'b0;
      if (ras_n)                      age <= '0;
      else if (age != CW'(TMAX))      age <= age + 1'b1;

      case (state)
        S_IDLE: begin
          if (ref_pend) begin
            addr  <= BUS_W'(ref_row);
            state <= S_REFSET;
          end else if (acc_go) begin
            addr   <= BUS_W'(acc_row);
            col_q  <= acc_col;
            wr_q   <= acc_wr;
            dq_out <= acc_wdata;
            state  <= S_ROWSET;
          end
        end
        S_ROWSET: begin
          ras_n <= 1'b0;
          cnt   <= CW'(T_RCD - 1);
          state <= S_RCD;
        end
        S_RCD: begin
          if (cnt == '0) begin
            addr  <= BUS_W'(col_q);
            we_n  <= ~wr_q;
            dq_oe <= wr_q;
            state <= S_COLSET;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_COLSET: begin
          cas_n <= 1'b0;
          oe_n  <= wr_q;
          cnt   <= CW'(T_CAS - 1);
          state <= S_CAS;
        end
        S_CAS: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (ras_met) begin
            if (!wr_q) begin
              rd_data  <= dq_in;
              rd_valid <= 1'b1;
            end
            cas_n <= 1'b1;
            ras_n <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            cnt   <= CW'(T_RP - 1);
            state <= S_PRE;
          end
        end
        S_REFSET: begin
          ras_n <= 1'b0;
          state <= S_REFLOW;
        end
        S_REFLOW: begin
          if (ras_met) begin
            ras_n    <= 1'b1;
            ref_done <= 1'b1;
            cnt      <= CW'(T_RP - 1);
            state    <= S_PRE;
          end
        end
        S_PRE: begin
          if (cnt == '0) state <= S_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mux_dram_ctrl.sv
`timescale 1ns/1ps
module mux_dram_ctrl #(
  parameter int ROW_W          = 12,
  parameter int COL_W          = 10,
  parameter int DATA_W         = 16,
  parameter int T_RCD          = 2,
  parameter int T_CAS          = 2,
  parameter int T_RAS          = 8,
  parameter int T_RP           = 3,
  parameter int REF_PERIOD_CYC = 12_800_000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   req_ready,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int BUS_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int ROWS    = 1 << ROW_W;
  localparam int REF_INT = REF_PERIOD_CYC / ROWS;

  logic             ref_pend;
  logic             ref_done;
  logic [ROW_W-1:0] ref_row;
  logic             idle;

  assign req_ready = idle & ~ref_pend;

  mdc_refresh #(.ROW_W(ROW_W), .INTERVAL(REF_INT)) refresh_i (
    .clk      (clk),
    .rst      (rst),
    .ref_done (ref_done),
    .ref_pend (ref_pend),
    .ref_row  (ref_row)
  );

  mdc_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BUS_W(BUS_W),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .T_RP(T_RP)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .acc_go    (req_valid & req_ready),
    .acc_wr    (req_write),
    .acc_row   (req_addr[ROW_W+COL_W-1:COL_W]),
    .acc_col   (req_addr[COL_W-1:0]),
    .acc_wdata (req_wdata),
    .ref_pend  (ref_pend),
    .ref_row   (ref_row),
    .idle      (idle),
    .ref_done  (ref_done),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .addr      (dram_addr),
    .dq_out    (dram_dq_out),
    .dq_oe     (dram_dq_oe),
    .dq_in     (dram_dq_in),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );
endmodule

// File: rtl/mdc_chk.sv
`timescale 1ns/1ps
module mdc_chk #(
  parameter int T_RAS  = 8,
  parameter int T_RP   = 3,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int BUS_W  = 12,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic [BUS_W-1:0]  addr,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic              rd_valid,
  input logic              req_ready,
  input logic              ref_pend
);
  localparam int BOUND = 2*T_RAS + T_RCD + T_CAS + T_RP + 8;

  logic [15:0] lo_c, hi_c, pend_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_c   <= '0;
      hi_c   <= 16'(T_RP);
      pend_c <= '0;
    end else begin
      lo_c   <= ras_n ? '0 : ((lo_c == 16'hFFFF) ? lo_c : lo_c + 1'b1);
      hi_c   <= !ras_n ? '0 : ((hi_c == 16'hFFFF) ? hi_c : hi_c + 1'b1);
      pend_c <= !ref_pend ? '0 : ((pend_c == 16'hFFFF) ? pend_c : pend_c + 1'b1);
    end
  end

  p_row_addr_stable_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> $stable(addr));
  p_col_stable_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> ($stable(addr) && $stable(we_n)));
  p_wdata_ready_r2: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && !we_n) |-> (dq_oe && $stable(dq_out)));
  p_cas_inside_ras_r3: assert property (@(posedge clk) disable iff (rst)
    !cas_n |-> !ras_n);
  p_rd_window_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(!ras_n && !cas_n && we_n && !oe_n));
  p_rd_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);
  p_ras_low_min_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (lo_c >= 16'(T_RAS)));
  p_precharge_min_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (hi_c >= 16'(T_RP)));
  p_rcd_min_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> (lo_c >= 16'(T_RCD)));
  p_ready_idle_r7: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (ras_n && cas_n));
  p_ref_deadline_r7: assert property (@(posedge clk) disable iff (rst)
    pend_c <= 16'(BOUND));
endmodule

bind mux_dram_ctrl mdc_chk #(
  .T_RAS(T_RAS), .T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS),
  .BUS_W(BUS_W), .DATA_W(DATA_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .ras_n     (dram_ras_n),
  .cas_n     (dram_cas_n),
  .we_n      (dram_we_n),
  .oe_n      (dram_oe_n),
  .addr      (dram_addr),
  .dq_out    (dram_dq_out),
  .dq_oe     (dram_dq_oe),
  .rd_valid  (rd_valid),
  .req_ready (req_ready),
  .ref_pend  (ref_pend)
);

// File: tb/mux_dram_ctrl_tb_top.sv
`timescale 1ns/1ps
module mux_dram_ctrl_tb_top;
  localparam int RW    = 3;
  localparam int CW    = 3;
  localparam int DW    = 8;
  localparam int TRCD  = 2;
  localparam int TCAS  = 2;
  localparam int TRAS  = 6;
  localparam int TRP   = 3;
  localparam int PER   = 320;
  localparam int NLOC  = 1 << (RW + CW);
  localparam int INT   = PER / (1 << RW);
  localparam int BOUND = 2*TRAS + TRCD + TCAS + TRP + 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [RW+CW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic [2:0]    dram_addr;
  logic          dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
  logic [DW-1:0] dram_dq_out;
  logic          dram_dq_oe;
  logic [DW-1:0] dram_dq_in;

  always #2.5 clk = ~clk;

  mux_dram_ctrl #(
    .ROW_W(RW), .COL_W(CW), .DATA_W(DW), .T_RCD(TRCD), .T_CAS(TCAS),
    .T_RAS(TRAS), .T_RP(TRP), .REF_PERIOD_CYC(PER)
  ) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
    .dram_dq_in(dram_dq_in)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  logic [DW-1:0]    mem [NLOC];
  logic [DW-1:0]    exp_mem [NLOC];
  logic [RW-1:0]    m_row = '0;
  logic [CW-1:0]    m_col = '0;
  bit               saw_cas = 1'b0;
  bit               rdy_seen = 1'b0;
  int               cur_addr = 0;
  int               cyc = 0;
  int               last_ref = 0;
  int               n_ref = 0;
  logic [RW-1:0]    exp_ref = '0;

  always @(posedge clk) cyc++;

  assign dram_dq_in = (!dram_ras_n && !dram_cas_n && dram_we_n && !dram_oe_n)
                      ? mem[{m_row, m_col}] : 8'h00;

  always @(negedge dram_ras_n) begin
    m_row    = dram_addr[RW-1:0];
    saw_cas  = 1'b0;
    rdy_seen = 1'b0;
  end

  always @(negedge dram_cas_n) begin
    if (!rst) begin
      m_col   = dram_addr[CW-1:0];
      saw_cas = 1'b1;
      // R1 row/column split as latched by the device
      chk({m_row, m_col} == cur_addr[RW+CW-1:0], "R1", int'({m_row, m_col}), cur_addr);
      if (!dram_we_n) begin
        chk(dram_dq_oe, "R2", int'(dram_dq_oe), 1);
        mem[{m_row, m_col}] = dram_dq_out;
      end
    end
  end

  always @(negedge clk) if (!dram_ras_n && req_ready) rdy_seen = 1'b1;

  always @(posedge dram_ras_n) begin
    if (!rst) begin
      chk(!rdy_seen, "R7 ready low while row open", int'(rdy_seen), 0);
      if (!saw_cas) begin
        chk(m_row == exp_ref, "R6 refresh row", int'(m_row), int'(exp_ref));
        chk((cyc - last_ref) <= INT + BOUND, "R7 refresh gap", cyc - last_ref, INT + BOUND);
        exp_ref  = exp_ref + 1'b1;
        last_ref = cyc;
        n_ref++;
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic access(input bit wr, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a[RW+CW-1:0]; req_wdata = d;
    cur_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (dram_cas_n) @(negedge clk);
    while (!dram_cas_n) @(negedge clk);
    if (wr) begin
      exp_mem[a] = d;
      chk(!rd_valid, "R4 no pulse on write", int'(rd_valid), 0);
    end else begin
      chk(rd_valid, "R4 valid with strobe release", int'(rd_valid), 1);
      chk(rd_data == exp_mem[a], "R4 read data", int'(rd_data), int'(exp_mem[a]));
      @(negedge clk);
      chk(!rd_valid, "R4 single pulse", int'(rd_valid), 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NLOC; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    repeat (4) @(negedge clk);
    // R8 reset state while reset is held
    chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R8 strobes", 0, 1);
    chk(!dram_dq_oe && !rd_valid, "R8 drive/valid", int'(dram_dq_oe), 0);
    rst = 1'b0;
    last_ref = cyc;
    @(negedge clk);
    chk(req_ready, "R8 ready after reset", int'(req_ready), 1);
    chk(dram_ras_n && dram_cas_n, "R8 strobes after reset", 0, 1);

    // pass 1: ascending writes, ascending reads
    for (int a = 0; a < NLOC; a++) access(1'b1, a, 8'(a*37 + 11));
    for (int a = 0; a < NLOC; a++) access(1'b0, a, '0);
    // pass 2: descending writes with a second pattern, strided reads
    for (int a = NLOC-1; a >= 0; a--) access(1'b1, a, 8'(~(a*13 + 7)));
    for (int k = 0; k < NLOC; k++) access(1'b0, (k*5) % NLOC, '0);

    // idle stretch: refreshes start without waiting, counter wraps (R6)
    repeat (3*PER) @(negedge clk);
    chk(n_ref >= (cyc / INT) - 2, "R7 refresh count", n_ref, (cyc / INT) - 2);
    chk(n_ref > (1 << RW) * 2, "R6 counter wrapped", n_ref, (1 << RW) * 2);
    chk(dram_ras_n || dram_cas_n, "R3 idle strobes", 0, 1);
    finish_run();
  end
endmodule